// File: doc/BRIEF.md
# DRAM Rank Boundary Address Decoder

This block resolves which DRAM rank, and which of two channels, holds a given physical address. Software programs a small register file with cumulative rank boundaries, a page-size code per rank and a bank-organisation code per rank. Each channel has four ranks. A lookup port then takes the address of interest and returns a registered result one cycle later. The result gives a hit flag, the rank index, the channel, the page size in KiB and whether the rank has eight banks.

The caller gives the address as two parts. The first is the 32 MB grain index, which is the physical address bits above bit 24. The second is physical address bit 0. Boundaries are counted in 32 MB grains. A boundary byte of 0x80 therefore marks 4 GB, so bit 7 is set exactly when a channel reaches 4 GB.

The block compares the four boundaries of channel 0 with those of channel 1. When all four pairs are equal, the block treats the channels as interleaved. In that case each boundary counts double, only ranks 0 to 3 exist, and address bit 0 picks the channel. Otherwise the eight boundaries form one cumulative chain. Channel 0 supplies ranks 0 to 3 and channel 1 supplies ranks 4 to 7.

Top module: `rbd_decoder`

## Requirements
- R1: A write with wr_addr[8]=1 and wr_addr[6:0]=r (r in 0..3) sets the boundary of rank r of channel wr_addr[7], so 0x100..0x103 address channel 0 and 0x180..0x183 address channel 1. Bits 1:0 of the written byte are ignored and stored as zero.
- R2: In single-channel mode, flat rank i (0..7) uses the boundary of channel i/4, rank i%4. A lookup hits flat rank i when the grain index g satisfies B(i-1) <= g < B(i), with B(-1)=0. Where several ranks match, the lowest index is reported, and res_chan equals res_rank[2].
- R3: A rank whose boundary equals the previous boundary, or lies below it, is never reported.
- R4: dual_mode is 1 exactly when each channel-0 boundary equals the matching channel-1 boundary. It follows the registers from the clock edge that writes them.
- R5: In dual-channel mode, rank i (0..3) spans 2*B0(i-1) <= g < 2*B0(i), res_chan equals address bit 0, and res_rank stays below 4.
- R6: A lookup that matches no rank, including any g at or above the highest boundary, returns res_valid=1 and res_hit=0. In that case res_rank, res_chan, res_page_kib and res_eight_banks are all 0.
- R7: The page-size bytes sit at offsets 0x08 (ranks 0,1) and 0x09 (ranks 2,3) of each channel, at 0x108/0x109 and 0x188/0x189. An even rank uses bits 2:0 and an odd rank uses bits 6:4. Code 010 gives 4, 011 gives 8 and 100 gives 16 on res_page_kib. Every other code, including 000 for an unpopulated rank, gives 0.
- R8: The bank byte sits at offset 0x0E of each channel (0x10E, 0x18E), with rank r in bits 2r+1:2r. Code 01 sets res_eight_banks and every other code clears it. In dual mode the attributes come from the channel given by address bit 0.
- R9: res_valid is high exactly one cycle after lk_valid. A lookup presented in the same cycle as a register write is decoded with the register contents from before that write.
- R10: Reset clears every register, so dual_mode=1 and every lookup misses, and it clears the result outputs.
- R11: Writes with wr_addr[8]=0, or with an offset other than 0..3, 0x08, 0x09 or 0x0E, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 9 | Register offset; bit 7 selects the channel |
| wr_data | input | 8 | Register write data |
| lk_valid | input | 1 | Lookup request |
| lk_grain | input | GRAIN_W (8) | Address bits above the 32 MB grain |
| lk_lane | input | 1 | Address bit 0 |
| res_valid | output | 1 | Result valid, one cycle after lk_valid |
| res_hit | output | 1 | Address falls inside a populated rank |
| res_rank | output | 3 | Rank index (0..7 single, 0..3 dual) |
| res_chan | output | 1 | Channel holding the address |
| res_page_kib | output | 5 | Page size in KiB, 0 when unpopulated or reserved |
| res_eight_banks | output | 1 | Rank has eight banks |
| dual_mode | output | 1 | Channels configured symmetrically |

## Verification
A register write and a lookup can fall in the same cycle. This matters most when the write moves the boundary that the looked-up address sits next to. The bench raises wr_en and lk_valid on the same falling edge, rewriting rank 0's boundary so that a grain moves from rank 1 into rank 0. The first result must still name rank 1, and a repeat lookup must name rank 0. Full sweeps of every grain index, in single and dual mode and in both lanes, are compared against a bench model built from the boundary arithmetic.

// File: rtl/rbd_pkg.sv
package rbd_pkg;

    // offsets inside a channel's register window (wr_addr[6:0])
    localparam logic [6:0] OFF_ATTR   = 7'h08;
    localparam logic [6:0] OFF_BANK   = 7'h0E;
    localparam logic [1:0] BANK_EIGHT = 2'b01;

    localparam logic [2:0] PG_4K  = 3'b010;
    localparam logic [2:0] PG_8K  = 3'b011;
    localparam logic [2:0] PG_16K = 3'b100;

    function automatic logic [4:0] page_kib_of(input logic [2:0] code);
        case (code)
            PG_4K:   return 5'd4;
            PG_8K:   return 5'd8;
            PG_16K:  return 5'd16;
            default: return 5'd0;
        endcase
    endfunction

endpackage

// File: rtl/rbd_regs.sv
module rbd_regs
    import rbd_pkg::*;
#(
    parameter int RANKS_PER_CH = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [8:0]                          wr_addr,
    input  logic [7:0]                          wr_data,
    output logic [1:0][RANKS_PER_CH-1:0][7:0]   bnd,
    output logic [1:0][RANKS_PER_CH-1:0][2:0]   attr,
    output logic [1:0][RANKS_PER_CH-1:0][1:0]   bank
);

    typedef struct packed {
        logic [1:0][RANKS_PER_CH-1:0][7:0] bnd;
        logic [1:0][RANKS_PER_CH-1:0][2:0] attr;
        logic [1:0][RANKS_PER_CH-1:0][1:0] bank;
    } regs_t;

    regs_t      regs_d, regs_q;
    logic       wr_ch;
    logic [6:0] wr_off;

    assign wr_ch  = wr_addr[7];
    assign wr_off = wr_addr[6:0];

    always_comb begin
        regs_d = regs_q;
        if (wr_en && wr_addr[8]) begin
            for (int i = 0; i < RANKS_PER_CH; i++) begin
                if (wr_off == 7'(i))
                    regs_d.bnd[wr_ch][i] = {wr_data[7:2], 2'b00};
                if (wr_off == 7'(OFF_ATTR + 7'(i / 2))) begin
                    if (i % 2 == 0)
                        regs_d.attr[wr_ch][i] = wr_data[2:0];
                    else
                        regs_d.attr[wr_ch][i] = wr_data[6:4];
                end
                if (wr_off == OFF_BANK)
                    regs_d.bank[wr_ch][i] = wr_data[2*i +: 2];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            regs_q <= '0;
        else
            regs_q <= regs_d;
    end

    assign bnd  = regs_q.bnd;
    assign attr = regs_q.attr;
    assign bank = regs_q.bank;

endmodule

// File: rtl/rbd_match.sv
module rbd_match #(
    parameter int RANKS_PER_CH = 4,
    parameter int GRAIN_W      = 8
) (
    input  logic [1:0][RANKS_PER_CH-1:0][7:0] bnd,
    input  logic                              dual,
    input  logic [GRAIN_W-1:0]                grain,
    output logic [2*RANKS_PER_CH-1:0]         hitv
);

    localparam int NRANK = 2 * RANKS_PER_CH;
    localparam int CW    = ((GRAIN_W > 8) ? GRAIN_W : 8) + 1;

    logic [CW-1:0] upper [NRANK];
    logic [CW-1:0] g_ext;

    assign g_ext = CW'(grain);

    for (genvar i = 0; i < NRANK; i++) begin : g_rank
        logic [CW-1:0] lower;

        if (i < RANKS_PER_CH) begin : g_ch0
            assign upper[i] = dual ? CW'({bnd[0][i], 1'b0}) : CW'(bnd[0][i]);
        end else begin : g_ch1
            assign upper[i] = CW'(bnd[1][i - RANKS_PER_CH]);
        end

        if (i == 0) begin : g_first
            assign lower = '0;
        end else begin : g_next
            assign lower = upper[i-1];
        end

        if (i < RANKS_PER_CH) begin : g_any
            assign hitv[i] = (g_ext >= lower) && (g_ext < upper[i]);
        end else begin : g_single
            assign hitv[i] = !dual && (g_ext >= lower) && (g_ext < upper[i]);
        end
    end

endmodule

// File: rtl/rbd_pick.sv
module rbd_pick #(
    parameter int N = 8
) (
    input  logic [N-1:0]         hitv,
    output logic                 any,
    output logic [$clog2(N)-1:0] idx
);

    always_comb begin
        any = |hitv;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hitv[i])
                idx = ($clog2(N))'(i);
        end
    end

endmodule

// File: rtl/rbd_decoder.sv
module rbd_decoder
    import rbd_pkg::*;
#(
    parameter int GRAIN_W      = 8,
    parameter int RANKS_PER_CH = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [8:0]                            wr_addr,
    input  logic [7:0]                            wr_data,
    input  logic                                  lk_valid,
    input  logic [GRAIN_W-1:0]                    lk_grain,
    input  logic                                  lk_lane,
    output logic                                  res_valid,
    output logic                                  res_hit,
    output logic [$clog2(2*RANKS_PER_CH)-1:0]     res_rank,
    output logic                                  res_chan,
    output logic [4:0]                            res_page_kib,
    output logic                                  res_eight_banks,
    output logic                                  dual_mode
);

    localparam int NRANK  = 2 * RANKS_PER_CH;
    localparam int RANK_W = $clog2(NRANK);
    localparam int RK_W   = $clog2(RANKS_PER_CH);

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic [RANK_W-1:0] rank;
        logic              chan;
        logic [4:0]        page_kib;
        logic              eight_banks;
    } res_t;

    logic [1:0][RANKS_PER_CH-1:0][7:0] bnd;
    logic [1:0][RANKS_PER_CH-1:0][2:0] attr;
    logic [1:0][RANKS_PER_CH-1:0][1:0] bank;
    logic [NRANK-1:0]                  hitv;
    logic                              any_hit;
    logic [RANK_W-1:0]                 hit_idx;
    logic                              sel_ch;
    logic [RK_W-1:0]                   sel_rk;
    res_t                              res_d, res_q;

    rbd_regs #(.RANKS_PER_CH(RANKS_PER_CH)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .bnd     (bnd),
        .attr    (attr),
        .bank    (bank)
    );

    assign dual_mode = (bnd[0] == bnd[1]);

    rbd_match #(.RANKS_PER_CH(RANKS_PER_CH), .GRAIN_W(GRAIN_W)) i_match (
        .bnd   (bnd),
        .dual  (dual_mode),
        .grain (lk_grain),
        .hitv  (hitv)
    );

    rbd_pick #(.N(NRANK)) i_pick (
        .hitv (hitv),
        .any  (any_hit),
        .idx  (hit_idx)
    );

    // channel: address lane when interleaved, upper half of the flat chain otherwise
    assign sel_ch = dual_mode ? lk_lane : hit_idx[RANK_W-1];
    assign sel_rk = hit_idx[RK_W-1:0];

    always_comb begin
        res_d       = '0;
        res_d.valid = lk_valid;
        if (lk_valid && any_hit) begin
            res_d.hit         = 1'b1;
            res_d.rank        = hit_idx;
            res_d.chan        = sel_ch;
            res_d.page_kib    = page_kib_of(attr[sel_ch][sel_rk]);
            res_d.eight_banks = (bank[sel_ch][sel_rk] == BANK_EIGHT);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            res_q <= '0;
        else
            res_q <= res_d;
    end

    assign res_valid       = res_q.valid;
    assign res_hit         = res_q.hit;
    assign res_rank        = res_q.rank;
    assign res_chan        = res_q.chan;
    assign res_page_kib    = res_q.page_kib;
    assign res_eight_banks = res_q.eight_banks;

endmodule

// File: rtl/rbd_checker.sv
module rbd_checker #(
    parameter int RANKS_PER_CH = 4
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               lk_valid,
    input logic                               lk_lane,
    input logic                               dual_mode,
    input logic                               res_valid,
    input logic                               res_hit,
    input logic [$clog2(2*RANKS_PER_CH)-1:0]  res_rank,
    input logic                               res_chan,
    input logic [4:0]                         res_page_kib,
    input logic                               res_eight_banks
);

    localparam int RANK_W = $clog2(2 * RANKS_PER_CH);

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    // R9
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);

    // R6
    hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> res_valid);

    // R6
    miss_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_rank == '0 && !res_chan &&
                                     res_page_kib == 5'd0 && !res_eight_banks));

    // R5
    dual_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && dual_mode) |=> (!res_hit ||
            (res_chan == $past(lk_lane) && res_rank < RANK_W'(RANKS_PER_CH))));

    // R2
    single_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !dual_mode) |=> (!res_hit || res_chan == res_rank[RANK_W-1]));

    // R7
    page_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_page_kib == 5'd0 || res_page_kib == 5'd4 ||
        res_page_kib == 5'd8 || res_page_kib == 5'd16);

endmodule

bind rbd_decoder rbd_checker #(.RANKS_PER_CH(RANKS_PER_CH)) i_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .lk_valid        (lk_valid),
    .lk_lane         (lk_lane),
    .dual_mode       (dual_mode),
    .res_valid       (res_valid),
    .res_hit         (res_hit),
    .res_rank        (res_rank),
    .res_chan        (res_chan),
    .res_page_kib    (res_page_kib),
    .res_eight_banks (res_eight_banks)
);

// File: tb/test_rbd_decoder.sv
`timescale 1ns/1ps
module test_rbd_decoder;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [8:0] wr_addr;
    logic [7:0] wr_data;
    logic       lk_valid;
    logic [7:0] lk_grain;
    logic       lk_lane;
    logic       res_valid, res_hit, res_chan, res_eight_banks, dual_mode;
    logic [2:0] res_rank;
    logic [4:0] res_page_kib;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    int mb [2][4];
    int ma [2][4];
    int mk [2][4];

    always #2.5 clk = ~clk;

    rbd_decoder i_rbd_decoder (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .lk_valid(lk_valid), .lk_grain(lk_grain), .lk_lane(lk_lane),
        .res_valid(res_valid), .res_hit(res_hit), .res_rank(res_rank), .res_chan(res_chan),
        .res_page_kib(res_page_kib), .res_eight_banks(res_eight_banks), .dual_mode(dual_mode)
    );

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic void model_clear();
        for (int c = 0; c < 2; c++)
            for (int r = 0; r < 4; r++) begin
                mb[c][r] = 0; ma[c][r] = 0; mk[c][r] = 0;
            end
    endfunction

    function automatic void model_wr(input logic [8:0] a, input logic [7:0] d);
        int c, off;
        if (!a[8]) return;
        c   = a[7];
        off = a[6:0];
        if (off < 4) mb[c][off] = d & 8'hFC;
        if (off == 8) begin ma[c][0] = d[2:0]; ma[c][1] = d[6:4]; end
        if (off == 9) begin ma[c][2] = d[2:0]; ma[c][3] = d[6:4]; end
        if (off == 14) for (int r = 0; r < 4; r++) mk[c][r] = (d >> (2 * r)) & 3;
    endfunction

    function automatic bit model_dual();
        for (int r = 0; r < 4; r++)
            if (mb[0][r] != mb[1][r]) return 0;
        return 1;
    endfunction

    function automatic logic [11:0] model_res(input int g, input bit lane);
        bit h = 0; int rk = 0; bit ch = 0; int lo = 0; int up; int code; int pk = 0; bit eb = 0;
        if (model_dual()) begin
            for (int i = 0; i < 4; i++) begin
                up = 2 * mb[0][i];
                if (!h && g >= lo && g < up) begin h = 1; rk = i; ch = lane; end
                lo = up;
            end
        end else begin
            for (int i = 0; i < 8; i++) begin
                up = mb[i / 4][i % 4];
                if (!h && g >= lo && g < up) begin h = 1; rk = i; ch = (i >= 4); end
                lo = up;
            end
        end
        if (h) begin
            code = ma[ch][rk % 4];
            pk   = (code == 2) ? 4 : (code == 3) ? 8 : (code == 4) ? 16 : 0;
            eb   = (mk[ch][rk % 4] == 1);
        end
        return {1'b1, h, 3'(rk), ch, 5'(pk), eb};
    endfunction

    function automatic logic [11:0] act_res();
        return {res_valid, res_hit, res_rank, res_chan, res_page_kib, res_eight_banks};
    endfunction

    task automatic wr(input logic [8:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
        model_wr(a, d);
    endtask

    task automatic look(input int g, input bit lane, input string tag);
        logic [11:0] e;
        e = model_res(g, lane);
        @(negedge clk);
        lk_valid = 1; lk_grain = 8'(g); lk_lane = lane;
        @(negedge clk);
        lk_valid = 0;
        cmp(tag, 32'(act_res()), 32'(e));
    endtask

    task automatic sweep(input bit lane, input string tag);
        for (int g = 0; g < 256; g++) look(g, lane, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        model_clear();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [11:0] e;
        rst_n = 0; wr_en = 0; wr_addr = '0; wr_data = '0;
        lk_valid = 0; lk_grain = '0; lk_lane = 0;
        model_clear();
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 reset state
        cmp("R10 res_valid", 32'(res_valid), 32'd0);
        cmp("R10 dual_mode", 32'(dual_mode), 32'd1);
        look(0, 0, "R10 lookup misses");

        // single-channel layout: rank 2 and rank 7 empty, top at 4 GB
        wr(9'h100, 8'h04); wr(9'h101, 8'h08); wr(9'h102, 8'h08); wr(9'h103, 8'h10);
        wr(9'h180, 8'h14); wr(9'h181, 8'h18); wr(9'h182, 8'h80); wr(9'h183, 8'h80);
        wr(9'h108, 8'h32); wr(9'h109, 8'h54); wr(9'h188, 8'h10); wr(9'h189, 8'h43);
        wr(9'h10E, 8'h1D); wr(9'h18E, 8'h44);
        cmp("R4 unequal channels", 32'(dual_mode), 32'd0);
        sweep(0, "R2 R3 R6 R7 R8 single sweep");

        // R1: low two boundary bits are dropped
        wr(9'h103, 8'h13);
        look(16, 0, "R1 masked bits rank3");
        look(18, 0, "R1 masked bits rank3");
        wr(9'h100, 8'h07);
        look(4, 0, "R1 masked bits rank0");

        // R11: unmapped offsets change nothing
        wr(9'h003, 8'h40); wr(9'h104, 8'h20); wr(9'h10A, 8'hFF); wr(9'h184, 8'h33);
        wr(9'h07E, 8'hFF);
        cmp("R11 dual unchanged", 32'(dual_mode), 32'd0);
        sweep(1, "R11 sweep after ignored writes");

        // R9: write and lookup in the same cycle
        e = model_res(5, 0);
        @(negedge clk);
        wr_en = 1; wr_addr = 9'h100; wr_data = 8'h08;
        lk_valid = 1; lk_grain = 8'd5; lk_lane = 0;
        @(negedge clk);
        wr_en = 0; lk_valid = 0;
        model_wr(9'h100, 8'h08);
        cmp("R9 lookup uses pre-write state", 32'(act_res()), 32'(e));
        cmp("R9 pre-write rank", 32'(res_rank), 32'd1);
        look(5, 0, "R9 lookup after write");
        cmp("R9 post-write rank", 32'(res_rank), 32'd0);
        @(negedge clk);
        cmp("R9 valid drops when idle", 32'(res_valid), 32'd0);

        // dual-channel layout
        wr(9'h100, 8'h08); wr(9'h101, 8'h10); wr(9'h102, 8'h10); wr(9'h180, 8'h08);
        wr(9'h181, 8'h10); wr(9'h182, 8'h10); wr(9'h183, 8'h20);
        cmp("R4 one pair differs", 32'(dual_mode), 32'd0);
        wr(9'h103, 8'h20);
        cmp("R4 all pairs equal", 32'(dual_mode), 32'd1);
        sweep(0, "R5 R7 R8 dual sweep lane0");
        sweep(1, "R5 R7 R8 dual sweep lane1");

        // break symmetry again
        wr(9'h183, 8'h24);
        cmp("R4 symmetry broken", 32'(dual_mode), 32'd0);
        sweep(1, "R2 R3 R6 single sweep");

        // R10: reset in mid-run clears the layout
        do_reset();
        cmp("R10 dual after reset", 32'(dual_mode), 32'd1);
        look(3, 1, "R10 miss after reset");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule